// File: doc/BRIEF.md
# Multi-Mode Triaxial Sample FIFO

This block buffers three-axis motion samples. Each X, Y and Z reading arrives together under one valid strobe and is kept as one entry. The buffer holds up to 32 entries, and a pop strobe moves the oldest stored entry into three output registers. A two-bit mode input sets what happens to incoming samples. In pass-through mode nothing is stored and the output registers are loaded directly. In hold mode the buffer fills and then drops new samples. In rolling mode the buffer keeps the newest 32 samples by replacing the oldest. Triggered mode starts as rolling and switches to hold when a trigger pulse arrives.

The host reads a live fill count and three flags: empty, full and a programmable watermark. Surrounding logic uses these flags to raise interrupts. The register access and the interrupt routing sit outside this block.

Top module: `tri_sample_fifo`

## Requirements
- R1: After reset the fill count is 0, the empty flag is 1, the full and watermark flags are 0 and all three output registers read 0.
- R2: With modeSel = 0 (pass-through), a sample presented with sampleValid appears on outX/outY/outZ one clock later. The fill count stays 0, the empty flag stays 1, and popStrobe has no effect on the outputs.
- R3: Any cycle with modeSel = 0 flushes the buffer, so that the fill count is 0 one clock later. Entries stored before the flush are never popped afterwards, and a pop after the flush leaves the outputs unchanged.
- R4: With modeSel = 1 (hold), samples are stored until the count reaches 32. A sample that arrives while the count is 32 is discarded, even when a pop happens in the same cycle.
- R5: In any mode other than pass-through, a pop with a nonzero count loads the oldest stored X, Y and Z together into the outputs one clock later and lowers the count by one. A pop on an empty buffer is ignored and the outputs hold their values.
- R6: With modeSel = 2 (rolling), a sample arriving at count 32 replaces the oldest entry and the count stays 32. A pop in that same cycle outputs the oldest entry before it is replaced.
- R7: With modeSel = 3 (triggered), the buffer behaves as in rolling mode until trigIn is seen high. From the following cycle it behaves as in hold mode. Leaving mode 3 clears the trigger.
- R8: wmFlag is 1 exactly when wmEnable is 1 and the fill count is greater than or equal to wmLevel.
- R9: emptyFlag is 1 exactly when the count is 0. fullFlag is 1 exactly when the count is 32. The count never exceeds 32.
- R10: A push and a pop in the same cycle on a buffer that is neither empty nor full leave the count unchanged. Entries still leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modeSel | input | 2 | 0 pass-through, 1 hold, 2 rolling, 3 triggered |
| trigIn | input | 1 | Trigger pulse for triggered mode |
| sampleValid | input | 1 | A new sample triplet is present |
| sampleX | input | 10 | X sample |
| sampleY | input | 10 | Y sample |
| sampleZ | input | 10 | Z sample |
| popStrobe | input | 1 | Pop the oldest entry into the outputs |
| wmEnable | input | 1 | Enables the watermark flag |
| wmLevel | input | 6 | Watermark threshold in entries |
| outX | output | 10 | X output register |
| outY | output | 10 | Y output register |
| outZ | output | 10 | Z output register |
| levelCount | output | 6 | Number of stored entries, 0 to 32 |
| emptyFlag | output | 1 | Count is zero |
| fullFlag | output | 1 | Count is 32 |
| wmFlag | output | 1 | Watermark reached |

## Verification
The assertions check these properties on every cycle: the count never goes above 32, a pass-through cycle always empties the buffer, a full buffer stays full in hold mode without a pop and in rolling mode under a push, an empty buffer with no push stays empty, and the outputs change only when a pop is taken or a pass-through sample arrives. Some behaviour only the bench scenarios can show. These are the data order through wrap-around, which entry is lost on overwrite, that discarded samples never come out, the switch from rolling to hold at the trigger, and that stale entries are gone after a flush.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_ROLL   = 2'd2,
    MODE_TRIG   = 2'd3
  } tsf_mode_e;

  typedef struct packed {
    logic wrEn;     // store the incoming triplet at the write pointer
    logic rdEn;     // load the oldest entry into the output registers
    logic advRd;    // retire the oldest entry (pop or overwrite)
    logic flush;    // return both pointers to slot zero
    logic passLoad; // load the incoming triplet straight into the outputs
  } tsf_strb_t;
endpackage

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      modeSel,
  input  logic            trigIn,
  input  logic            sampleValid,
  input  logic            popStrobe,
  input  logic            wmEnable,
  input  logic [LVLW-1:0] wmLevel,
  output tsf_strb_t       strb,
  output logic [LVLW-1:0] levelCount,
  output logic            emptyFlag,
  output logic            fullFlag,
  output logic            wmFlag
);
  localparam logic [LVLW-1:0] FULL_LVL = LVLW'(DEPTH);

  tsf_mode_e       mode;
  logic [LVLW-1:0] level;
  logic            trigSeen;
  logic            isPass, rollLike, isFull, isEmpty;
  logic            popOk, pushOk, advRd;

  assign mode = tsf_mode_e'(modeSel);

  always_comb begin
    isPass   = (mode == MODE_PASS);
    rollLike = (mode == MODE_ROLL) || ((mode == MODE_TRIG) && !trigSeen);
    isFull   = (level == FULL_LVL);
    isEmpty  = (level == '0);
    popOk    = !isPass && popStrobe && !isEmpty;
    pushOk   = !isPass && sampleValid && (!isFull || rollLike);
    advRd    = popOk || (pushOk && isFull);
    strb.wrEn     = pushOk;
    strb.rdEn     = popOk;
    strb.advRd    = advRd;
    strb.flush    = isPass;
    strb.passLoad = isPass && sampleValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else if (isPass) begin
      level <= '0;
    end else if (pushOk && !advRd) begin
      level <= level + 1'b1;
    end else if (!pushOk && advRd) begin
      level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trigSeen <= 1'b0;
    end else if (mode != MODE_TRIG) begin
      trigSeen <= 1'b0;
    end else if (trigIn) begin
      trigSeen <= 1'b1;
    end
  end

  assign levelCount = level;
  assign emptyFlag  = isEmpty;
  assign fullFlag   = isFull;
  assign wmFlag     = wmEnable && (level >= wmLevel);

  // R9: the count is bounded by the depth
  a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    levelCount <= FULL_LVL);

  // R3: a pass-through cycle empties the buffer
  a_r3_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'd0) |=> emptyFlag);

  // R4: hold behaviour never leaves full without a pop
  a_r4_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!isPass && !rollLike && fullFlag && !popStrobe) |=> fullFlag);

  // R6: rolling behaviour keeps a full buffer full under a push
  a_r6_roll_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rollLike && fullFlag && sampleValid) |=> fullFlag);

  // R5: a pop on an empty buffer with no push leaves it empty
  a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (emptyFlag && !sampleValid) |=> emptyFlag);
endmodule

// File: rtl/tsf_data.sv
module tsf_data
  import tsf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 10,
  parameter int PTRW  = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tsf_strb_t     strb,
  input  logic [DW-1:0] sampleX,
  input  logic [DW-1:0] sampleY,
  input  logic [DW-1:0] sampleZ,
  output logic [DW-1:0] outX,
  output logic [DW-1:0] outY,
  output logic [DW-1:0] outZ
);
  localparam int EW = 3 * DW;
  localparam logic [PTRW-1:0] LAST = PTRW'(DEPTH - 1);

  logic [EW-1:0]   slots [DEPTH];
  logic [PTRW-1:0] wrPtr, rdPtr;
  logic [EW-1:0]   oldest, incoming;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign incoming = {sampleX, sampleY, sampleZ};
  assign oldest   = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.wrEn) slots[wrPtr] <= incoming;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrEn)  wrPtr <= bump(wrPtr);
      if (strb.advRd) rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {outX, outY, outZ} <= '0;
    end else if (strb.passLoad) begin
      {outX, outY, outZ} <= incoming;
    end else if (strb.rdEn) begin
      {outX, outY, outZ} <= oldest;
    end
  end

  // R5: outputs move only on a taken pop or a pass-through sample
  a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.rdEn && !strb.passLoad) |=> $stable({outX, outY, outZ}));

  // R2: pass-through never writes the storage
  a_r2_pass_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |-> !strb.wrEn);
endmodule

// File: rtl/tri_sample_fifo.sv
module tri_sample_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 10,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      modeSel,
  input  logic            trigIn,
  input  logic            sampleValid,
  input  logic [DW-1:0]   sampleX,
  input  logic [DW-1:0]   sampleY,
  input  logic [DW-1:0]   sampleZ,
  input  logic            popStrobe,
  input  logic            wmEnable,
  input  logic [LVLW-1:0] wmLevel,
  output logic [DW-1:0]   outX,
  output logic [DW-1:0]   outY,
  output logic [DW-1:0]   outZ,
  output logic [LVLW-1:0] levelCount,
  output logic            emptyFlag,
  output logic            fullFlag,
  output logic            wmFlag
);
  tsf_strb_t strb;

  tsf_ctrl #(.DEPTH(DEPTH), .LVLW(LVLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .trigIn(trigIn),
    .sampleValid(sampleValid), .popStrobe(popStrobe),
    .wmEnable(wmEnable), .wmLevel(wmLevel), .strb(strb),
    .levelCount(levelCount), .emptyFlag(emptyFlag),
    .fullFlag(fullFlag), .wmFlag(wmFlag)
  );

  tsf_data #(.DEPTH(DEPTH), .DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .sampleX(sampleX), .sampleY(sampleY), .sampleZ(sampleZ),
    .outX(outX), .outY(outY), .outZ(outZ)
  );
endmodule

// File: tb/sim_tri_sample_fifo.sv
`timescale 1ns/1ps
module sim_tri_sample_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic       trigIn = 1'b0, sampleValid = 1'b0, popStrobe = 1'b0;
  logic [9:0] sampleX = '0, sampleY = '0, sampleZ = '0;
  logic       wmEnable = 1'b1;
  logic [5:0] wmLevel = 6'd16;
  logic [9:0] outX, outY, outZ;
  logic [5:0] levelCount;
  logic       emptyFlag, fullFlag, wmFlag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tri_sample_fifo u0 (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .trigIn(trigIn),
    .sampleValid(sampleValid), .sampleX(sampleX), .sampleY(sampleY),
    .sampleZ(sampleZ), .popStrobe(popStrobe), .wmEnable(wmEnable),
    .wmLevel(wmLevel), .outX(outX), .outY(outY), .outZ(outZ),
    .levelCount(levelCount), .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .wmFlag(wmFlag)
  );

  typedef struct packed {
    logic       v;
    logic       p;
    logic [9:0] x;
    logic [5:0] lvl;
    logic [9:0] ox;
  } vec_t;

  // hold mode walk: push / pop / both / empty pop
  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 10'd5, 6'd1, 10'd0},
    '{1'b1, 1'b0, 10'd6, 6'd2, 10'd0},
    '{1'b0, 1'b1, 10'd0, 6'd1, 10'd5},
    '{1'b1, 1'b1, 10'd7, 6'd1, 10'd6},
    '{1'b0, 1'b1, 10'd0, 6'd0, 10'd7},
    '{1'b0, 1'b1, 10'd0, 6'd0, 10'd7},
    '{1'b1, 1'b0, 10'd8, 6'd1, 10'd7},
    '{1'b1, 1'b1, 10'd9, 6'd1, 10'd8}
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic p, input logic [9:0] x, input logic t);
    sampleValid = v; popStrobe = p; trigIn = t;
    sampleX = x; sampleY = x + 10'd100; sampleZ = x + 10'd200;
    @(negedge clk);
    sampleValid = 1'b0; popStrobe = 1'b0; trigIn = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m);
    modeSel = m;
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 level", levelCount, 0);
    check("R1 empty", emptyFlag, 1);
    check("R1 full", fullFlag, 0);
    check("R1 wm", wmFlag, 0);
    check("R1 outX", outX, 0);

    // R5 R10 table walk in hold mode
    setMode(2'd1);
    for (int i = 0; i < 8; i++) begin
      step(VEC[i].v, VEC[i].p, VEC[i].x, 1'b0);
      check("R10 table level", levelCount, VEC[i].lvl);
      check("R5 table outX", outX, VEC[i].ox);
    end
    check("R5 table outZ", outZ, 8 + 200);

    // R4 fill, discard at full, drain in order; R8 R9 flags
    setMode(2'd0);
    setMode(2'd1);
    for (int i = 0; i < 32; i++) begin
      step(1'b1, 1'b0, 10'(i), 1'b0);
      check("R8 wm during fill", wmFlag, (i + 1 >= 16) ? 1 : 0);
    end
    check("R9 full at 32", fullFlag, 1);
    step(1'b1, 1'b0, 10'd99, 1'b0);
    check("R4 discard level", levelCount, 32);
    step(1'b1, 1'b1, 10'd98, 1'b0);
    check("R4 push with pop at full discarded", levelCount, 31);
    check("R4 first out", outX, 0);
    wmEnable = 1'b0;
    @(negedge clk);
    check("R8 wm disabled", wmFlag, 0);
    wmEnable = 1'b1;
    for (int i = 1; i < 32; i++) begin
      step(1'b0, 1'b1, 10'd0, 1'b0);
      check("R4 drain order", outX, i);
    end
    check("R9 empty after drain", emptyFlag, 1);
    check("R4 outY last", outY, 31 + 100);

    // R6 rolling mode
    setMode(2'd0);
    setMode(2'd2);
    for (int i = 0; i < 36; i++) step(1'b1, 1'b0, 10'(i), 1'b0);
    check("R6 level stays 32", levelCount, 32);
    step(1'b1, 1'b1, 10'd50, 1'b0);
    check("R6 push+pop full level", levelCount, 32);
    check("R6 push+pop full oldest", outX, 4);
    for (int i = 5; i < 36; i++) begin
      step(1'b0, 1'b1, 10'd0, 1'b0);
      check("R6 roll order", outX, i);
    end
    step(1'b0, 1'b1, 10'd0, 1'b0);
    check("R6 newest last", outX, 50);
    check("R6 empty", emptyFlag, 1);

    // R7 triggered mode
    setMode(2'd0);
    setMode(2'd3);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 10'(i), 1'b0);
    check("R7 rolling before trigger", levelCount, 32);
    step(1'b0, 1'b0, 10'd0, 1'b1);
    step(1'b1, 1'b0, 10'd77, 1'b0);
    step(1'b0, 1'b1, 10'd0, 1'b0);
    check("R7 oldest after trigger", outX, 8);
    check("R7 discard after trigger", levelCount, 31);
    step(1'b1, 1'b0, 10'd78, 1'b0);
    step(1'b1, 1'b0, 10'd79, 1'b0);
    check("R7 hold after trigger", levelCount, 32);
    setMode(2'd0);
    setMode(2'd3);
    for (int i = 0; i < 34; i++) step(1'b1, 1'b0, 10'(i), 1'b0);
    step(1'b0, 1'b1, 10'd0, 1'b0);
    check("R7 trigger cleared, rolling again", outX, 2);

    // R2 pass-through
    setMode(2'd0);
    step(1'b1, 1'b0, 10'd123, 1'b0);
    check("R2 pass outX", outX, 123);
    check("R2 pass outZ", outZ, 323);
    check("R2 pass level", levelCount, 0);
    check("R2 pass empty", emptyFlag, 1);
    step(1'b0, 1'b1, 10'd0, 1'b0);
    check("R2 pop ignored", outX, 123);

    // R3 flush
    setMode(2'd1);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 10'(200 + i), 1'b0);
    check("R3 before flush", levelCount, 3);
    setMode(2'd0);
    check("R3 flushed level", levelCount, 0);
    setMode(2'd1);
    step(1'b0, 1'b1, 10'd0, 1'b0);
    check("R3 no stale entry", outX, 123);
    step(1'b1, 1'b0, 10'd44, 1'b0);
    step(1'b0, 1'b1, 10'd0, 1'b0);
    check("R3 new entry after flush", outX, 44);

    // R8 low threshold
    wmLevel = 6'd2;
    step(1'b1, 1'b0, 10'd1, 1'b0);
    check("R8 below", wmFlag, 0);
    step(1'b1, 1'b0, 10'd2, 1'b0);
    check("R8 at level", wmFlag, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule